// File: doc/BRIEF.md
# Reset and Interrupt Vector Front-End

This block sits in front of a small microcoded 8-bit processor with a 16-bit address space. It starts the machine and steers it into interrupt service. It owns the memory address register (MAR), the program counter (PC) and the microprogram counter (uPC). While reset is held, it pins the address register to the restart vector and clears the microprogram counter. The program counter is never written by reset. Instead, the first completed read after reset copies the restart vector from the address register into the PC.

A falling edge on the active-low non-maskable request is synchronised and then held in a sticky flag until the service microcode acknowledges it. That flag is ORed with the maskable request, gated by its enable, to form one interrupt condition. The microcode presents an instruction-boundary strobe. When the condition is true at a boundary, the block emits a one-cycle take pulse and loads the address register with the vector address. It picks 0xFFFA when the non-maskable flag is set and 0xFFFE otherwise. Interrupt state never reaches the microcode ROM address. It only steers this vector choice.

Top module: `vec_front`

## Requirements
- R1: While `rst` is high, each clock edge sets `mar` to 0xFFFC and `upc` to 0x00, and clears the non-maskable flag, so `vec_nmi` reads 0.
- R2: Reset leaves `pc` unchanged. The first `fetch_done` after reset releases copies `mar` into `pc`, whatever the values of `pc_inc` and `pc_load`.
- R3: After that first read, an edge with `fetch_done` and `pc_load` both high copies `mar` into `pc`. The copy takes precedence over `pc_inc`.
- R4: An edge with `fetch_done` and `pc_inc` high and `pc_load` low adds one to `pc`, wrapping from 0xFFFF to 0x0000. When `fetch_done` is low, `pc` holds.
- R5: The `nmi_n` input passes through two synchronising flops, and a falling edge then sets the non-maskable flag. The flag, seen on `vec_nmi`, reads 1 after the third rising clock edge following the fall.
- R6: The flag stays set until an edge with `nmi_ack` high clears it. A falling edge that arrives while the flag is already set is dropped and does not set the flag again after the acknowledge.
- R7: `int_take` equals `insn_bnd` AND (flag OR (`irq` AND `irq_en`)) while `rst` is low. It is combinational.
- R8: On an edge with `int_take` high, `mar` loads 0xFFFA if the flag is set and 0xFFFE otherwise. This load takes precedence over `mar_ld`.
- R9: `irq` is a level input and is not stored. A request that drops before a boundary produces no `int_take`.
- R10: Reset overrides interrupts. While `rst` is high, `int_take` is 0 and a pending non-maskable flag is discarded.
- R11: Without reset or `int_take`, an edge with `mar_ld` high loads `mar_din` into `mar`. Otherwise `mar` holds.
- R12: Outside reset, `upc` loads `upc_din` on an edge with `upc_ld` high, and otherwise increments by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| nmi_n | input | 1 | Asynchronous active-low non-maskable request |
| irq | input | 1 | Maskable request, level |
| irq_en | input | 1 | Maskable request enable |
| nmi_ack | input | 1 | Clears the non-maskable flag |
| insn_bnd | input | 1 | Instruction boundary strobe |
| fetch_done | input | 1 | Read cycle completes this edge |
| pc_inc | input | 1 | Increment PC on fetch_done |
| pc_load | input | 1 | Copy MAR into PC on fetch_done |
| mar_ld | input | 1 | Load MAR from mar_din |
| mar_din | input | 16 | Address for normal MAR loads |
| upc_ld | input | 1 | Load uPC from upc_din |
| upc_din | input | 8 | Microprogram jump target |
| mar | output | 16 | Memory address register |
| pc | output | 16 | Program counter |
| upc | output | 8 | Microprogram counter |
| int_take | output | 1 | Interrupt accepted this cycle |
| vec_nmi | output | 1 | Non-maskable flag; selects the 0xFFFA vector |

## Verification
The assertions check on every cycle the properties that hold one edge at a time. These are the reset values of MAR and uPC, the vector loaded after a take, the take occurring only at a boundary and never under reset, the PC holding without a read, and the flag staying set until acknowledged. Some behaviours only the bench scenarios can show. These are the PC capturing the restart vector on the first read after reset, the three-edge synchroniser latency, a second edge being dropped while the flag is set, and a short maskable pulse leaving no trace.

// File: rtl/vec_front.sv
module vec_front #(
  parameter int AW = 16,
  parameter int UW = 8,
  parameter logic [AW-1:0] RST_VEC = 16'hFFFC,
  parameter logic [AW-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nmi_n,
  input  logic          irq,
  input  logic          irq_en,
  input  logic          nmi_ack,
  input  logic          insn_bnd,
  input  logic          fetch_done,
  input  logic          pc_inc,
  input  logic          pc_load,
  input  logic          mar_ld,
  input  logic [AW-1:0] mar_din,
  input  logic          upc_ld,
  input  logic [UW-1:0] upc_din,
  output logic [AW-1:0] mar,
  output logic [AW-1:0] pc,
  output logic [UW-1:0] upc,
  output logic          int_take,
  output logic          vec_nmi
);
  logic [2:0] nsync;
  logic       nflag, boot;

  wire nfall = nsync[2] & ~nsync[1];

  assign int_take = ~rst & insn_bnd & (nflag | (irq & irq_en));
  assign vec_nmi  = nflag;

  always_ff @(posedge clk) begin
    nsync <= {nsync[1:0], nmi_n};
    if (rst)
      nsync <= 3'b111;
  end

  always_ff @(posedge clk) begin
    if (rst || nmi_ack)
      nflag <= 1'b0;
    else if (nfall)
      nflag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      mar <= RST_VEC;
    else if (int_take)
      mar <= nflag ? NMI_VEC : IRQ_VEC;
    else if (mar_ld)
      mar <= mar_din;
  end

  always_ff @(posedge clk) begin
    if (rst)
      boot <= 1'b1;
    else if (fetch_done)
      boot <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst && fetch_done) begin
      if (boot || pc_load)
        pc <= mar;
      else if (pc_inc)
        pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      upc <= '0;
    else if (upc_ld)
      upc <= upc_din;
    else
      upc <= upc + 1'b1;
  end
endmodule

module vec_front_chk #(
  parameter int AW = 16,
  parameter int UW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          insn_bnd,
  input logic          fetch_done,
  input logic          nmi_ack,
  input logic [AW-1:0] mar,
  input logic [AW-1:0] pc,
  input logic [UW-1:0] upc,
  input logic          int_take,
  input logic          vec_nmi
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (mar == 16'hFFFC && upc == '0 && !vec_nmi));
  a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !fetch_done |=> $stable(pc));
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst || !armed)
    (vec_nmi && !nmi_ack) |=> vec_nmi);
  a_r7_take_at_boundary: assert property (@(posedge clk) disable iff (!armed)
    int_take |-> insn_bnd);
  a_r8_vector: assert property (@(posedge clk) disable iff (rst || !armed)
    int_take |=> (mar == ($past(vec_nmi) ? 16'hFFFA : 16'hFFFE)));
  a_r10_reset_blocks_take: assert property (@(posedge clk) disable iff (!armed)
    rst |-> !int_take);
endmodule

bind vec_front vec_front_chk #(.AW(AW), .UW(UW)) u_chk (
  .clk(clk), .rst(rst), .insn_bnd(insn_bnd), .fetch_done(fetch_done),
  .nmi_ack(nmi_ack), .mar(mar), .pc(pc), .upc(upc),
  .int_take(int_take), .vec_nmi(vec_nmi)
);

// File: tb/vec_front_tb.sv
module vec_front_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, nmi_n, irq, irq_en, nmi_ack, insn_bnd, fetch_done, pc_inc, pc_load;
  logic mar_ld, upc_ld;
  logic [15:0] mar_din, mar, pc;
  logic [7:0] upc_din, upc;
  logic int_take, vec_nmi;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  vec_front u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, m;
    rst = 1; nmi_n = 1; irq = 0; irq_en = 0; nmi_ack = 0; insn_bnd = 0;
    fetch_done = 0; pc_inc = 0; pc_load = 0; mar_ld = 0; upc_ld = 0;
    mar_din = 0; upc_din = 0;
    cyc(3);
    chk("R1 mar", mar, 16'hFFFC);
    chk("R1 upc", upc, 0);
    chk("R1 flag", vec_nmi, 0);
    insn_bnd = 1; irq = 1; irq_en = 1; mar_ld = 1; mar_din = 16'h1234; #1;
    chk("R10 take under reset", int_take, 0);
    cyc();
    chk("R10 mar stays vector", mar, 16'hFFFC);
    insn_bnd = 0; irq = 0; irq_en = 0; mar_ld = 0;
    rst = 0;
    cyc();
    chk("R12 upc inc", upc, 1);
    fetch_done = 1; pc_inc = 1;
    cyc();
    chk("R2 pc from mar on first read", pc, 16'hFFFC);
    v = 16'hFFFC;
    for (int i = 0; i < 4; i++) begin
      cyc();
      v = v + 1;
      chk("R4 pc increment", pc, v);
    end
    fetch_done = 0;
    cyc(2);
    chk("R4 pc hold", pc, v);
    fetch_done = 1; pc_inc = 0;
    cyc();
    chk("R4 no action hold", pc, v);
    fetch_done = 0;

    for (int i = 0; i < 64; i++) begin
      m = 16'(i * 1031) ^ 16'hA5A5;
      mar_ld = 1; mar_din = m;
      cyc();
      chk("R11 mar load", mar, m);
      mar_ld = 0; mar_din = ~m; fetch_done = 1; pc_load = 1; pc_inc = 1;
      cyc();
      chk("R11 mar hold", mar, m);
      chk("R3 pc load beats inc", pc, m);
      fetch_done = 0; pc_load = 0; pc_inc = 0;
    end

    upc_ld = 1; upc_din = 8'h5A;
    cyc();
    chk("R12 upc load", upc, 8'h5A);
    upc_ld = 0;
    cyc();
    chk("R12 upc inc after load", upc, 8'h5B);

    for (int k = 0; k < 8; k++) begin
      irq = k[0]; irq_en = k[1]; insn_bnd = k[2];
      mar_ld = 1; mar_din = 16'h1000 + 16'(k);
      #1;
      chk("R7 take", int_take, k[0] & k[1] & k[2]);
      cyc();
      chk("R8 irq vector / priority", mar, (k[0] & k[1] & k[2]) ? 16'hFFFE : 16'h1000 + 16'(k));
    end
    mar_ld = 0;

    irq = 1; irq_en = 1; insn_bnd = 0;
    cyc();
    irq = 0; insn_bnd = 1; #1;
    chk("R9 irq not latched", int_take, 0);
    insn_bnd = 0;

    nmi_n = 0;
    cyc(2);
    chk("R5 flag after two edges", vec_nmi, 0);
    cyc();
    chk("R5 flag after three edges", vec_nmi, 1);
    insn_bnd = 1; irq = 1; #1;
    chk("R7 take on nmi", int_take, 1);
    cyc();
    chk("R8 nmi vector", mar, 16'hFFFA);
    insn_bnd = 0; irq = 0;
    nmi_n = 1; cyc(3); nmi_n = 0; cyc(4);
    chk("R6 flag sticky", vec_nmi, 1);
    nmi_ack = 1; cyc(); nmi_ack = 0;
    chk("R6 ack clears", vec_nmi, 0);
    cyc(4);
    chk("R6 no queued nmi", vec_nmi, 0);
    insn_bnd = 1; #1;
    chk("R7 no request no take", int_take, 0);
    insn_bnd = 0;

    nmi_n = 1; cyc(3); nmi_n = 0; cyc(4);
    chk("R5 second nmi sets", vec_nmi, 1);
    rst = 1; cyc();
    chk("R10 reset discards nmi", vec_nmi, 0);
    chk("R1 mar again", mar, 16'hFFFC);
    rst = 0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule